// File: doc/BRIEF.md
# DMA Channel Bus Arbiter

This block decides which of N_CH DMA channels owns the single bus master of a DMA controller. Each channel may raise a one-move peripheral request, a multi-move peripheral request, or a software request. A request that reaches an enabled channel is held in a pending flag. The arbiter grants the bus to one pending channel through a one-hot vector. It keeps that grant while the channel engine reports moves, and it re-arbitrates only when the channel's burst is complete.

Each channel has three control bits: enable, request mask and high priority. Each bit is written through its own pair of one-hot strobe vectors, one that sets and one that clears, and the current bit values are driven on readback outputs. The channel engine supplies a one-cycle strobe for every data move. For each channel it also supplies a 4-bit burst exponent and a flag marking the channel as served by a peripheral that only issues single requests. A global enable stops all granting. All pins are plain control and status signals; there is no streaming interface and so no back-pressure.

Top module: `dma_chan_arbiter`

## Requirements
- R1: `grant` is zero or one-hot. Among pending, enabled channels of the same priority class, the lowest index wins.
- R2: A pending channel whose high-priority bit is 1 is granted before any channel whose bit is 0, whatever the indices.
- R3: For the enable, mask and priority bits, a 1 on a set strobe sets the bit at the next clock edge and a 1 on a clear strobe clears it. A 0 leaves the bit unchanged. If set and clear strike the same bit in the same cycle, the clear wins. The readback outputs show the new value one cycle after the write.
- R4: Bits [4*i+3:4*i] of `burst_pow` hold the exponent p of channel i. Once granted, channel i keeps `grant` for 2^p `move_done` pulses. After the last pulse, `grant` is zero for exactly one cycle and then re-arbitration takes place.
- R5: When `single_only[i]` is 1, channel i loses the grant after each single move, whatever its exponent.
- R6: While a channel's mask bit is 1, its peripheral requests are neither latched nor granted, not even after the mask is cleared. Its software request is still latched and granted.
- R7: A channel whose enable bit is 0 is never newly granted, and requests that arrive while it is disabled are dropped.
- R8: While `glb_en` is 0, `grant` is zero from the next cycle on. A burst cut short this way keeps its channel pending, and the channel is granted again once `glb_en` returns to 1.
- R9: A one-cycle request pulse is latched and leads to a grant two clock edges after it was sampled. The pending flag clears when the grant is issued, so a request that arrives during a channel's own burst gets that channel granted again after the burst.
- R10: After reset, `grant` and all control bits are zero and no request is pending.
- R11: A `move_done` pulse while `grant` is zero has no effect on the length of the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable for all grants |
| per_single_req | input | N_CH | One-move peripheral request per channel |
| per_burst_req | input | N_CH | Multi-move peripheral request per channel |
| sw_req | input | N_CH | Software request per channel |
| single_only | input | N_CH | Channel is served by a single-request-only peripheral |
| burst_pow | input | N_CH*4 | Burst exponent per channel, 4 bits each |
| move_done | input | 1 | One data move finished by the granted channel |
| en_set | input | N_CH | Set strobes for the enable bits |
| en_clr | input | N_CH | Clear strobes for the enable bits |
| mask_set | input | N_CH | Set strobes for the request mask bits |
| mask_clr | input | N_CH | Clear strobes for the request mask bits |
| hp_set | input | N_CH | Set strobes for the high-priority bits |
| hp_clr | input | N_CH | Clear strobes for the high-priority bits |
| grant | output | N_CH | One-hot bus grant, all zero when idle |
| ch_en | output | N_CH | Current enable bits |
| ch_mask | output | N_CH | Current mask bits |
| ch_hp | output | N_CH | Current high-priority bits |

## Verification
The arbitration function is tested with several request patterns. Two simultaneous requests of equal class show whether index order decides. A low-index software request against a high-index high-priority peripheral request shows whether the priority class overrides index order. A higher-priority request that arrives in the middle of another channel's burst shows whether the arbiter waits for the burst to finish or preempts it. The same channel requesting again during its own burst shows whether the pending flag clears at grant time or at burst end. Masked peripheral pulses, software pulses on masked channels, and pulses to disabled channels show which request types are kept. Exponent-versus-single-only runs and a global enable drop in the middle of a burst show exactly when the grant is given up.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {ARB_IDLE, ARB_OWN} arb_state_t;
endpackage

// File: rtl/dma_arb_ctlreg.sv
module dma_arb_ctlreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // clear takes precedence over set on the same bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o | set_i) & ~clr_i;
  end
endmodule

// File: rtl/dma_arb_reqlatch.sv
module dma_arb_reqlatch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] per_single_i,
  input  logic [W-1:0] per_burst_i,
  input  logic [W-1:0] sw_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] take_i,
  input  logic [W-1:0] restore_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] fresh;

  always_comb begin
    fresh = (sw_i | ((per_single_i | per_burst_i) & ~mask_i)) & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~take_i) | fresh | restore_i;
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int W = 16
) (
  input  logic [W-1:0] cand_i,
  input  logic [W-1:0] hp_i,
  output logic [W-1:0] sel_o
);
  logic [W-1:0] hp_cand;
  logic [W-1:0] hp_first;
  logic [W-1:0] lo_first;
  logic [W:0]   hp_seen;
  logic [W:0]   lo_seen;

  assign hp_cand    = cand_i & hp_i;
  assign hp_seen[0] = 1'b0;
  assign lo_seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_scan
    assign hp_first[i]  = hp_cand[i] & ~hp_seen[i];
    assign lo_first[i]  = cand_i[i] & ~lo_seen[i];
    assign hp_seen[i+1] = hp_seen[i] | hp_cand[i];
    assign lo_seen[i+1] = lo_seen[i] | cand_i[i];
  end

  assign sel_o = hp_seen[W] ? hp_first : lo_first;
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int N_CH  = 16,
  parameter int POW_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  glb_en,
  input  logic [N_CH-1:0]       per_single_req,
  input  logic [N_CH-1:0]       per_burst_req,
  input  logic [N_CH-1:0]       sw_req,
  input  logic [N_CH-1:0]       single_only,
  input  logic [N_CH*POW_W-1:0] burst_pow,
  input  logic                  move_done,
  input  logic [N_CH-1:0]       en_set,
  input  logic [N_CH-1:0]       en_clr,
  input  logic [N_CH-1:0]       mask_set,
  input  logic [N_CH-1:0]       mask_clr,
  input  logic [N_CH-1:0]       hp_set,
  input  logic [N_CH-1:0]       hp_clr,
  output logic [N_CH-1:0]       grant,
  output logic [N_CH-1:0]       ch_en,
  output logic [N_CH-1:0]       ch_mask,
  output logic [N_CH-1:0]       ch_hp
);
  import dma_arb_pkg::*;

  localparam int CNT_W  = (1 << POW_W) - 1;
  localparam int SPAN_W = CNT_W + 1;

  arb_state_t        state_q;
  logic [N_CH-1:0]   grant_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [N_CH-1:0]   pend;
  logic [N_CH-1:0]   cand;
  logic [N_CH-1:0]   sel;
  logic [N_CH-1:0]   take;
  logic [N_CH-1:0]   restore;
  logic [POW_W-1:0]  own_pow;
  logic              own_single;
  logic              own_live;
  logic [SPAN_W-1:0] span;
  logic [SPAN_W-1:0] lim;
  logic              last_move;
  logic              start;
  logic              abort;

  dma_arb_ctlreg #(.W(N_CH)) u_en   (.clk(clk), .rst_n(rst_n), .set_i(en_set),   .clr_i(en_clr),   .q_o(ch_en));
  dma_arb_ctlreg #(.W(N_CH)) u_mask (.clk(clk), .rst_n(rst_n), .set_i(mask_set), .clr_i(mask_clr), .q_o(ch_mask));
  dma_arb_ctlreg #(.W(N_CH)) u_hp   (.clk(clk), .rst_n(rst_n), .set_i(hp_set),   .clr_i(hp_clr),   .q_o(ch_hp));

  dma_arb_reqlatch #(.W(N_CH)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .per_single_i(per_single_req), .per_burst_i(per_burst_req), .sw_i(sw_req),
    .mask_i(ch_mask), .en_i(ch_en), .take_i(take), .restore_i(restore),
    .pend_o(pend)
  );

  assign cand = pend & ch_en;

  dma_arb_pick #(.W(N_CH)) u_pick (.cand_i(cand), .hp_i(ch_hp), .sel_o(sel));

  // attributes of the current owner
  always_comb begin
    own_pow = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (grant_q[i]) own_pow = own_pow | burst_pow[i*POW_W +: POW_W];
    end
  end

  assign own_single = |(grant_q & single_only);
  assign own_live   = |(grant_q & ch_en);
  assign span       = SPAN_W'(1) << own_pow;
  assign lim        = span - SPAN_W'(1);
  assign last_move  = own_single || ({1'b0, cnt_q} == lim);

  assign start   = (state_q == ARB_IDLE) && glb_en && (|cand);
  assign abort   = (state_q == ARB_OWN) && (!glb_en || !own_live);
  assign take    = start ? sel : '0;
  assign restore = abort ? grant_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      grant_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (start) begin
            grant_q <= sel;
            cnt_q   <= '0;
            state_q <= ARB_OWN;
          end
        end
        ARB_OWN: begin
          if (abort) begin
            grant_q <= '0;
            state_q <= ARB_IDLE;
          end else if (move_done) begin
            if (last_move) begin
              grant_q <= '0;
              state_q <= ARB_IDLE;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: state_q <= ARB_IDLE;
      endcase
    end
  end

  assign grant = grant_q;
endmodule

// File: rtl/dma_arb_chk.sv
module dma_arb_chk #(
  parameter int N_CH = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            glb_en,
  input logic            move_done,
  input logic [N_CH-1:0] grant,
  input logic [N_CH-1:0] ch_en
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1

  AST_GLB_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> (grant == '0)); // R8

  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && !move_done && glb_en && (|(grant & ch_en))) |=> (grant == $past(grant))); // R4

  AST_GRANT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> ((grant == '0) || (grant == $past(grant)))); // R4

  AST_NEW_GRANT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ($past(grant) == '0)) |-> (|(grant & $past(ch_en)))); // R7
endmodule

bind dma_chan_arbiter dma_arb_chk #(.N_CH(N_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .move_done(move_done),
  .grant(grant), .ch_en(ch_en)
);

// File: tb/dma_chan_arbiter_tb_top.sv
module dma_chan_arbiter_tb_top;
  localparam int N  = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          glb_en = 1'b0;
  logic [N-1:0]  per_single_req = '0, per_burst_req = '0, sw_req = '0, single_only = '0;
  logic [N*PW-1:0] burst_pow = '0;
  logic          move_done = 1'b0;
  logic [N-1:0]  en_set = '0, en_clr = '0, mask_set = '0, mask_clr = '0, hp_set = '0, hp_clr = '0;
  logic [N-1:0]  grant, ch_en, ch_mask, ch_hp;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma_chan_arbiter #(.N_CH(N), .POW_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .per_single_req(per_single_req), .per_burst_req(per_burst_req), .sw_req(sw_req),
    .single_only(single_only), .burst_pow(burst_pow), .move_done(move_done),
    .en_set(en_set), .en_clr(en_clr), .mask_set(mask_set), .mask_clr(mask_clr),
    .hp_set(hp_set), .hp_clr(hp_clr),
    .grant(grant), .ch_en(ch_en), .ch_mask(ch_mask), .ch_hp(ch_hp)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic moves(input int n);
    for (int k = 0; k < n; k++) begin
      move_done = 1'b1;
      step();
    end
    move_done = 1'b0;
  endtask

  task automatic pulse_sw(input logic [N-1:0] v);
    sw_req = v; step(); sw_req = '0;
  endtask

  task automatic set_pow(input int ch, input int p);
    burst_pow[ch*PW +: PW] = PW'(p);
  endtask

  task automatic t_reset();
    check("R10 grant", grant, '0);
    check("R10 enable", ch_en, '0);
    check("R10 mask/hp", ch_mask | ch_hp, '0);
  endtask

  task automatic t_ctlbits();
    en_set = 16'h00F5; step(); en_set = '0; step();
    check("R3 set", ch_en, 16'h00F5);
    en_clr = 16'h0005; step(); en_clr = '0; step();
    check("R3 clear", ch_en, 16'h00F0);
    step();
    check("R3 zero write no effect", ch_en, 16'h00F0);
    hp_set = 16'h0003; hp_clr = 16'h0001; step(); hp_set = '0; hp_clr = '0; step();
    check("R3 clear wins", ch_hp, 16'h0002);
    hp_clr = 16'h0002; en_set = 16'hFFFF; step(); hp_clr = '0; en_set = '0; step();
    check("R3 all enabled", ch_en, 16'hFFFF);
  endtask

  task automatic t_index();
    per_single_req = 16'h0028; step(); per_single_req = '0; step();
    check("R1 lower index first", grant, 16'h0008);
    check("R9 pulse granted", grant, 16'h0008);
    moves(1);
    check("R4 gap after burst", grant, '0);
    step();
    check("R1 next channel", grant, 16'h0020);
    moves(1); step();
    check("R1 idle", grant, '0);
  endtask

  task automatic t_hp();
    hp_set = 16'h0200; step(); hp_set = '0;
    sw_req = 16'h0004; per_burst_req = 16'h0200; step();
    sw_req = '0; per_burst_req = '0; step();
    check("R2 high priority wins", grant, 16'h0200);
    moves(1); step();
    check("R2 low class after", grant, 16'h0004);
    moves(1); step();
    hp_clr = 16'h0200; step(); hp_clr = '0;
  endtask

  task automatic t_burst();
    set_pow(1, 2);
    pulse_sw(16'h0002); step();
    check("R4 grant ch1", grant, 16'h0002);
    per_burst_req = 16'h0001; step(); per_burst_req = '0;
    moves(3);
    check("R4 held for burst", grant, 16'h0002);
    moves(1);
    check("R4 released after 4", grant, '0);
    step();
    check("R4 rearbitrate", grant, 16'h0001);
    moves(1); step();
    single_only[1] = 1'b1;
    pulse_sw(16'h0002); step();
    moves(1);
    check("R5 single-only releases", grant, '0);
    step();
    check("R5 idle", grant, '0);
    single_only[1] = 1'b0;
    set_pow(1, 0);
  endtask

  task automatic t_idle_moves();
    set_pow(7, 1);
    moves(3);
    pulse_sw(16'h0080); step();
    check("R11 grant ch7", grant, 16'h0080);
    moves(1);
    check("R11 burst not shortened", grant, 16'h0080);
    moves(1);
    check("R11 burst ends", grant, '0);
    step();
    set_pow(7, 0);
  endtask

  task automatic t_mask();
    mask_set = 16'h0010; step(); mask_set = '0; step();
    check("R6 mask readback", ch_mask, 16'h0010);
    per_single_req = 16'h0010; per_burst_req = 16'h0010; step();
    per_single_req = '0; per_burst_req = '0; step(); step();
    check("R6 masked periph ignored", grant, '0);
    mask_clr = 16'h0010; step(); mask_clr = '0; step(); step();
    check("R6 not latched", grant, '0);
    mask_set = 16'h0010; step(); mask_set = '0;
    pulse_sw(16'h0010); step();
    check("R6 sw honoured", grant, 16'h0010);
    moves(1); step();
    mask_clr = 16'h0010; step(); mask_clr = '0;
  endtask

  task automatic t_disabled();
    en_clr = 16'h0040; step(); en_clr = '0;
    pulse_sw(16'h0040); step(); step();
    check("R7 disabled not granted", grant, '0);
    en_set = 16'h0040; step(); en_set = '0; step(); step();
    check("R7 request dropped", grant, '0);
  endtask

  task automatic t_global();
    glb_en = 1'b0;
    pulse_sw(16'h0004); step(); step();
    check("R8 no grant when off", grant, '0);
    glb_en = 1'b1; step();
    check("R8 pending kept", grant, 16'h0004);
    set_pow(5, 3);
    moves(1); step();
    pulse_sw(16'h0020); step();
    check("R8 ch5 granted", grant, 16'h0020);
    moves(2);
    glb_en = 1'b0; step();
    check("R8 abort", grant, '0);
    glb_en = 1'b1; step();
    check("R8 regrant", grant, 16'h0020);
    moves(7);
    check("R8 burst restarted", grant, 16'h0020);
    moves(1); step();
    set_pow(5, 0);
  endtask

  task automatic t_rerequest();
    set_pow(0, 1);
    pulse_sw(16'h0001); step();
    check("R9 ch0 granted", grant, 16'h0001);
    pulse_sw(16'h0001);
    moves(2);
    check("R9 gap", grant, '0);
    step();
    check("R9 regranted", grant, 16'h0001);
    moves(2); step();
    check("R9 no stale pending", grant, '0);
    set_pow(0, 0);
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_ctlbits();
    glb_en = 1'b1;
    t_index();
    t_hp();
    t_burst();
    t_idle_moves();
    t_mask();
    t_disabled();
    t_global();
    t_rerequest();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule